// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Arbiter

This block chooses which processor receives an interrupt when several are eligible. Each processor owns a task priority register that its software rewrites on every context switch to say how important its current work is. When a request arrives with a mask of eligible processors, the block grants the interrupt to the eligible processor that is doing the least important work, i.e. the one with the smallest task priority.

Processors that share the smallest task priority are separated by a 4-bit arbitration rank held per processor. The winner of each delivery drops to rank 0, and every other processor climbs by one, so processors that have waited longest rise to the top. A rank that would climb past 15 is instead reloaded with one more than the winner's former rank. The result is a registered one-hot grant and a grant-valid flag one cycle after the request.

Top module: `irq_lowpri_arbiter`

## Requirements
- R1: After reset `grant` is all zero, `grant_valid` is 0, every task priority register holds 0 and processor i holds arbitration rank i.
- R2: Only processors whose bit is set in `req_mask` can be granted; a cycle with `req_valid` low, or with an all-zero mask, leaves `grant_valid` at 0 and `grant` at zero in the next cycle.
- R3: The granted processor has the smallest task priority among the masked processors.
- R4: Among masked processors tied at the smallest task priority, the one with the highest arbitration rank wins; a remaining tie goes to the lowest processor index.
- R5: The grant is registered: a request sampled at one rising edge shows on `grant`/`grant_valid` right after that edge, and `grant` is one-hot whenever `grant_valid` is 1.
- R6: On each grant the winner's arbitration rank becomes 0 and every other processor's rank, eligible or not, rises by 1.
- R7: A non-winning processor whose rank is 15 at a grant is instead loaded with the winner's previous rank plus 1, taken modulo 16.
- R8: Processor i writes its task priority by raising bit i of `tpr_we` with the value in `tpr_wdata[i*TPR_W +: TPR_W]`; a write in the same cycle as a request affects only later requests.
- R9: A cycle without a grant leaves every arbitration rank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Interrupt request present this cycle |
| req_mask | input | NUM_CPU | Eligible processors, bit i for processor i |
| tpr_we | input | NUM_CPU | Task priority write strobe per processor |
| tpr_wdata | input | NUM_CPU*TPR_W | Task priority write data, field i for processor i |
| grant | output | NUM_CPU | One-hot chosen processor |
| grant_valid | output | 1 | A grant was made for the previous cycle's request |

## Verification
A task priority write and a request can land in the same cycle, and the chosen processor must then be judged on the old priority. The bench provokes this by raising the would-be winner's priority in the very cycle it requests, expecting that winner still, and then expecting a different winner on the next request. Separately, a grant can coincide with a rank overflow on an ineligible processor; the bench keeps one processor masked out across many grants so its rank saturates and must reload from the winner's old rank, which later tie-breaks reveal.

// File: rtl/irq_lp_pkg.sv
package irq_lp_pkg;
    localparam int ARB_W   = 4;
    localparam int ARB_MAX = (1 << ARB_W) - 1;

    typedef logic [ARB_W-1:0] arb_t;

    // next rank of a processor that did not win
    function automatic arb_t arb_climb(input arb_t cur, input arb_t win_old);
        arb_t res;
        if (cur == arb_t'(ARB_MAX)) res = win_old + arb_t'(1);
        else                        res = cur + arb_t'(1);
        return res;
    endfunction
endpackage

// File: rtl/irq_lp_tpr_bank.sv
module irq_lp_tpr_bank #(
    parameter int NUM_CPU = 4,
    parameter int TPR_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CPU-1:0]              wr_en,
    input  logic [NUM_CPU-1:0][TPR_W-1:0]   wr_data,
    output logic [NUM_CPU-1:0][TPR_W-1:0]   tpr
);
    typedef struct packed {
        logic [NUM_CPU-1:0][TPR_W-1:0] tpr;
    } tpr_state_t;

    tpr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (wr_en[i]) st_d.tpr[i] = wr_data[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tpr = st_q.tpr;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
        AST_TPR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> tpr[g] == $past(wr_data[g])); // R8
        AST_TPR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(tpr[g])); // R8
    end
endmodule

// File: rtl/irq_lp_arb_bank.sv
module irq_lp_arb_bank
    import irq_lp_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [NUM_CPU-1:0]      win_onehot,
    input  arb_t                    win_arb,
    output arb_t [NUM_CPU-1:0]      arb
);
    typedef struct packed {
        arb_t [NUM_CPU-1:0] rank;
    } arb_state_t;

    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            for (int i = 0; i < NUM_CPU; i++) begin
                if (win_onehot[i]) st_d.rank[i] = '0;
                else               st_d.rank[i] = arb_climb(st_q.rank[i], win_arb);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CPU; i++) st_q.rank[i] <= arb_t'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign arb = st_q.rank;

    AST_RANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(arb)); // R9

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
        AST_WINNER_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && win_onehot[g]) |=> arb[g] == '0); // R6
        AST_LOSER_CLIMBS: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && !win_onehot[g] && arb[g] != arb_t'(ARB_MAX))
            |=> arb[g] == $past(arb[g]) + arb_t'(1)); // R6
        AST_OVERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && !win_onehot[g] && arb[g] == arb_t'(ARB_MAX))
            |=> arb[g] == $past(win_arb) + arb_t'(1)); // R7
    end
endmodule

// File: rtl/irq_lp_select.sv
module irq_lp_select
    import irq_lp_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int TPR_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CPU-1:0]              mask,
    input  logic [NUM_CPU-1:0][TPR_W-1:0]   tpr,
    input  arb_t [NUM_CPU-1:0]              arb,
    output logic [NUM_CPU-1:0]              win_onehot,
    output logic                            any,
    output logic [TPR_W-1:0]                win_tpr,
    output arb_t                            win_arb
);
    always_comb begin
        win_onehot = '0;
        any        = 1'b0;
        win_tpr    = '0;
        win_arb    = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (mask[i]) begin
                if (!any || (tpr[i] < win_tpr) ||
                    (tpr[i] == win_tpr && arb[i] > win_arb)) begin
                    any           = 1'b1;
                    win_tpr       = tpr[i];
                    win_arb       = arb[i];
                    win_onehot    = '0;
                    win_onehot[i] = 1'b1;
                end
            end
        end
    end

    AST_ANY_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        any == (mask != '0)); // R2

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
        AST_WIN_LOWEST_TPR: assert property (@(posedge clk) disable iff (!rst_n)
            (any && mask[g]) |-> tpr[g] >= win_tpr); // R3
        AST_TIE_BY_RANK: assert property (@(posedge clk) disable iff (!rst_n)
            (any && mask[g] && tpr[g] == win_tpr) |-> arb[g] <= win_arb); // R4
    end
endmodule

// File: rtl/irq_lowpri_arbiter.sv
module irq_lowpri_arbiter
    import irq_lp_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int TPR_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [NUM_CPU-1:0]          req_mask,
    input  logic [NUM_CPU-1:0]          tpr_we,
    input  logic [NUM_CPU*TPR_W-1:0]    tpr_wdata,
    output logic [NUM_CPU-1:0]          grant,
    output logic                        grant_valid
);
    typedef struct packed {
        logic [NUM_CPU-1:0] grant;
        logic               valid;
    } out_state_t;

    logic [NUM_CPU-1:0][TPR_W-1:0] wdata_lane;
    logic [NUM_CPU-1:0][TPR_W-1:0] tpr_cur;
    arb_t [NUM_CPU-1:0]            arb_cur;
    logic [NUM_CPU-1:0]            win_onehot;
    logic                          win_any;
    logic [TPR_W-1:0]              win_tpr;
    arb_t                          win_arb;
    logic                          fire;
    logic [NUM_CPU-1:0]            eff_mask;
    out_state_t                    st_d, st_q;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_lane
        assign wdata_lane[g] = tpr_wdata[g*TPR_W +: TPR_W];
    end

    assign eff_mask = req_valid ? req_mask : '0;

    irq_lp_tpr_bank #(.NUM_CPU(NUM_CPU), .TPR_W(TPR_W)) u_tpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tpr_we),
        .wr_data (wdata_lane),
        .tpr     (tpr_cur)
    );

    irq_lp_select #(.NUM_CPU(NUM_CPU), .TPR_W(TPR_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (eff_mask),
        .tpr        (tpr_cur),
        .arb        (arb_cur),
        .win_onehot (win_onehot),
        .any        (win_any),
        .win_tpr    (win_tpr),
        .win_arb    (win_arb)
    );

    assign fire = win_any;

    irq_lp_arb_bank #(.NUM_CPU(NUM_CPU)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .win_onehot (win_onehot),
        .win_arb    (win_arb),
        .arb        (arb_cur)
    );

    always_comb begin
        st_d.valid = fire;
        st_d.grant = fire ? win_onehot : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant       = st_q.grant;
    assign grant_valid = st_q.valid;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $countones(grant) == 1); // R5
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> grant == '0); // R2
    AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(req_valid) && ((grant & $past(req_mask)) != '0)); // R2
endmodule

// File: tb/irq_lowpri_arbiter_tb_top.sv
module irq_lowpri_arbiter_tb_top;
    localparam int N  = 4;
    localparam int TW = 8;

    typedef struct {
        logic         valid;
        logic [N-1:0] grant;
        string        tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [N-1:0]    req_mask = '0;
    logic [N-1:0]    tpr_we = '0;
    logic [N*TW-1:0] tpr_wdata = '0;
    logic [N-1:0]    grant;
    logic            grant_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    exp_t sb[$];

    int m_tpr [N];
    int m_arb [N];

    always #5 clk = ~clk;

    irq_lowpri_arbiter #(.NUM_CPU(N), .TPR_W(TW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_mask    (req_mask),
        .tpr_we      (tpr_we),
        .tpr_wdata   (tpr_wdata),
        .grant       (grant),
        .grant_valid (grant_valid)
    );

    task automatic check(input string tag, input logic [N-1:0] g, input logic v,
                         input logic [N-1:0] eg, input logic ev);
        compared++;
        if (g !== eg || v !== ev) begin
            mismatched++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b", tag, g, v, eg, ev);
        end
    endtask

    // drive one cycle at the falling edge and push the expected outcome
    task automatic drive(input bit v, input logic [N-1:0] m, input logic [N-1:0] we,
                         input logic [N*TW-1:0] wd, input string tag);
        exp_t e;
        int w;
        int wold;
        @(negedge clk);
        req_valid = v; req_mask = m; tpr_we = we; tpr_wdata = wd;
        w = -1;
        if (v) begin
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    if (w < 0 || m_tpr[i] < m_tpr[w] ||
                        (m_tpr[i] == m_tpr[w] && m_arb[i] > m_arb[w])) w = i;
                end
            end
        end
        e.valid = (w >= 0);
        e.grant = '0;
        if (w >= 0) e.grant[w] = 1'b1;
        e.tag = tag;
        sb.push_back(e);
        if (w >= 0) begin
            wold = m_arb[w];
            for (int i = 0; i < N; i++) begin
                if (i == w)              m_arb[i] = 0;
                else if (m_arb[i] == 15) m_arb[i] = (wold + 1) % 16;
                else                     m_arb[i] = m_arb[i] + 1;
            end
        end
        for (int i = 0; i < N; i++) if (we[i]) m_tpr[i] = int'(wd[i*TW +: TW]);
    endtask

    task automatic set_tpr(input int a, input int b, input int c, input int d, input string tag);
        drive(1'b0, '0, 4'hF, {TW'(d), TW'(c), TW'(b), TW'(a)}, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(e.tag, grant, grant_valid, e.grant, e.valid);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run hung, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < N; i++) begin m_tpr[i] = 0; m_arb[i] = i; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", grant, grant_valid, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", grant, grant_valid, '0, 1'b0);

        // R1/R4: all priorities 0 so ranks decide; reset ranks pick CPU3 first
        drive(1'b1, 4'hF, '0, '0, "R1 R4 first pick by reset rank");
        drive(1'b1, 4'hF, '0, '0, "R4 R6 rotation");
        drive(1'b1, 4'hF, '0, '0, "R4 R6 rotation");
        drive(1'b1, 4'hF, '0, '0, "R4 R6 rotation");
        // R2: no request, empty mask
        drive(1'b0, 4'hF, '0, '0, "R2 no request");
        drive(1'b1, 4'h0, '0, '0, "R2 R9 empty mask");
        drive(1'b1, 4'h0, '0, '0, "R2 R9 empty mask");
        drive(1'b1, 4'hF, '0, '0, "R9 ranks held after empty mask");
        // R2: single eligible
        drive(1'b1, 4'h4, '0, '0, "R2 only masked CPU");

        // R3: distinct priorities
        set_tpr(5, 2, 2, 9, "R8 write");
        drive(1'b1, 4'hF, '0, '0, "R3 R4 lowest tpr with tie");
        drive(1'b1, 4'hF, '0, '0, "R3 R4 lowest tpr with tie");
        drive(1'b1, 4'h9, '0, '0, "R3 lowest among masked");
        drive(1'b1, 4'h8, '0, '0, "R3 only high tpr masked");

        // R8: same-cycle write raises tpr of expected winner
        set_tpr(1, 4, 4, 4, "R8 write");
        drive(1'b1, 4'hF, 4'h1, {TW'(4), TW'(4), TW'(4), TW'(200)}, "R8 same-cycle write uses old tpr");
        drive(1'b1, 4'hF, '0, '0, "R8 new tpr applies later");

        // R7: keep CPU3 out while CPU0 wins repeatedly
        set_tpr(0, 0, 0, 0, "R8 write");
        for (int k = 0; k < 20; k++) drive(1'b1, 4'h1, '0, '0, "R6 R7 repeated single winner");
        for (int k = 0; k < 6; k++)  drive(1'b1, 4'hF, '0, '0, "R7 ranks after overflow");
        drive(1'b1, 4'hE, '0, '0, "R4 R7 tie after overflow");

        // mixed pattern
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 300; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                drive(lf[0], lf[4:1], {3'b000, lf[5] & lf[6]} << lf[8:7],
                      {4{lf[11:9], lf[13:12]}} & {N*TW{1'b1}} , "R3 R4 R6 R7 R8 mixed");
            end
        end
        drive(1'b0, '0, '0, '0, "R2 idle tail");
        repeat (3) @(posedge clk);
        #2;
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL R5: %0d expected grants never compared, expected 0", sb.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule